// File: doc/BRIEF.md
# Sixteen-Line Transmit DMA Sequencer

This block moves outgoing characters from memory to up to sixteen serial transmitters. Each line owns a 16-bit current-address register, a 2-bit upper-address extension and a 16-bit byte counter. Software reaches one line's pair at a time through a line-select field in the control/status register. It loads the counter with the negative of the number of bytes to send. It then starts the line by setting that line's bit in the active bitmap.

A single sequencer picks among lines that are both active and ready to take a byte. It chooses in round-robin order, starting after the line it served last. It issues one byte read to the memory port at a time and hands the returned byte to the chosen line's transmitter in the cycle the memory acknowledges it. It then advances that line's address and count. When a count reaches zero, the line's active bit drops and the transmit-done flag rises. If the memory never answers, the sequencer gives up after a bounded wait, drops the line and sets a missing-memory flag. A separate break bitmap holds chosen lines in the spacing state. A master-clear bit resets all per-line state.

Top module: `txdma_mux`

## Requirements
- R1: Register index 0 is control/status, 1 is the selected line's current address, 2 is the selected line's byte count, 3 is the active bitmap and 4 is the break bitmap. Control/status bits 3:0 choose the line that indices 1 and 2 reach, and each line keeps its own address and count.
- R2: Only one memory read is outstanding at a time. Address and request stay steady until acknowledge or timeout. The returned byte appears on the transmit byte bus with a one-hot load strobe for its line in the cycle of the acknowledge.
- R3: After each delivered byte, the line's address rises by one and its count rises by one. Bytes come from consecutive addresses starting at the programmed one.
- R4: Writing the active register sets the written one-bits and leaves the others alone. A line's active bit clears by itself once its count reaches zero.
- R5: Completion of a line sets control/status bit 15. The interrupt output is bit 15 AND the enable bit 13. Writing 0 to bit 15 clears it, and writing 1 leaves it unchanged.
- R6: Control/status bits 5:4 written together with the select are copied into the line's upper address bits when its address is written. On read they show the selected line's current upper bits. A carry out of address bit 15 increments them.
- R7: Writing all-ones (−1) to an active line's count makes it send exactly one more byte and then stop. Its address then points just past that byte.
- R8: Lines are served round-robin from the line after the last one served, and only while their ready input is high. A line that is active but not ready causes no memory request.
- R9: A read that gets no acknowledge within NXM_LIMIT cycles sets control/status bit 10. It also clears the line's active bit, leaves its address and count unchanged, and sets bit 15. Writing 1 to bit 8 clears bit 10.
- R10: The spacing output for line n follows bit n of the break register.
- R11: Writing 1 to control/status bit 11 zeroes the active and break bitmaps and every line's address, extension and count, and abandons any outstanding read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Register write strobe |
| cfgAddr | input | 3 | Register index |
| cfgWdata | input | 16 | Register write data |
| cfgRdata | output | 16 | Register read data (combinational on cfgAddr) |
| memReq | output | 1 | Byte read request |
| memAddr | output | 18 | Byte read address |
| memAck | input | 1 | Read acknowledge, data valid |
| memData | input | 8 | Read data |
| txReady | input | 16 | Per-line transmitter can accept a byte |
| txLoad | output | 16 | One-hot per-line byte load strobe |
| txByte | output | 8 | Byte handed to the loaded line |
| txSpace | output | 16 | Per-line forced spacing |
| txIrq | output | 1 | Transmit interrupt request |

## Verification
Three lines with different counts run together, and the bench checks the exact service order against round-robin from the last served line. A design that restarted its search at line 0 would serve line 2 twice before line 9. An address at 0xFFFF with extension 1 must roll into extension 2; a design that drops the carry would fetch from 0x10000. A count rewritten to −1 while the line waits on its ready input must yield exactly one byte, because an off-by-one there sends zero bytes or two. A silent memory must end in the missing-memory flag with the line dropped and its address unmoved, and master clear must leave every window register reading zero.

// File: rtl/txdma_pkg.sv
package txdma_pkg;

  // register indices on the configuration port
  localparam logic [2:0] REG_CSR = 3'd0;
  localparam logic [2:0] REG_CAR = 3'd1;
  localparam logic [2:0] REG_CNT = 3'd2;
  localparam logic [2:0] REG_ACT = 3'd3;
  localparam logic [2:0] REG_BRK = 3'd4;

  // control/status bit positions
  localparam int CSR_DONE   = 15;
  localparam int CSR_DONEEN = 13;
  localparam int CSR_MCLR   = 11;
  localparam int CSR_NXM    = 10;
  localparam int CSR_NXMCLR = 8;
  localparam int CSR_EXTLSB = 4;

  // strobes from the sequencer to the register datapath
  typedef struct packed {
    logic advance;  // byte delivered for the served line
    logic abort;    // read timed out for the served line
  } stepStrobe_t;

endpackage

// File: rtl/txdma_linereg.sv
module txdma_linereg #(
  parameter int ADDR_W = 16,
  parameter int EXT_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clr,
  input  logic              carWe,
  input  logic              cntWe,
  input  logic              bump,
  input  logic [ADDR_W-1:0] wdata,
  input  logic [EXT_W-1:0]  extIn,
  output logic [ADDR_W-1:0] carOut,
  output logic [EXT_W-1:0]  extOut,
  output logic [ADDR_W-1:0] cntOut,
  output logic              lastByte
);

  localparam int FULL_W = ADDR_W + EXT_W;

  logic [ADDR_W-1:0] carR;
  logic [EXT_W-1:0]  extR;
  logic [ADDR_W-1:0] cntR;
  logic [FULL_W-1:0] bumped;

  assign bumped = {extR, carR} + FULL_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN || clr) begin
      carR <= '0;
      extR <= '0;
      cntR <= '0;
    end else begin
      if (bump) begin
        {extR, carR} <= bumped;
        cntR         <= cntR + ADDR_W'(1);
      end
      // software writes take priority over the hardware advance
      if (carWe) begin
        carR <= wdata;
        extR <= extIn;
      end
      if (cntWe) cntR <= wdata;
    end
  end

  assign carOut   = carR;
  assign extOut   = extR;
  assign cntOut   = cntR;
  assign lastByte = &cntR;

endmodule

// File: rtl/txdma_dpath.sv
module txdma_dpath
  import txdma_pkg::*;
#(
  parameter int LINES  = 16,
  parameter int ADDR_W = 16,
  parameter int EXT_W  = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     cfgWe,
  input  logic [2:0]               cfgAddr,
  input  logic [ADDR_W-1:0]        cfgWdata,
  output logic [ADDR_W-1:0]        cfgRdata,
  input  logic [$clog2(LINES)-1:0] svcLine,
  input  stepStrobe_t              step,
  output logic [EXT_W+ADDR_W-1:0]  lineAddr,
  output logic [LINES-1:0]         activeBits,
  output logic [LINES-1:0]         breakBits,
  output logic                     lineDone,
  output logic                     doneFlag,
  output logic                     doneEn,
  output logic                     nxmFlag,
  output logic                     mclrPulse
);

  localparam int SEL_W = $clog2(LINES);

  logic [SEL_W-1:0] selLine;
  logic [EXT_W-1:0] extStage;
  logic             csrWr, carWr, cntWr, actWr, brkWr;
  logic [LINES-1:0] clrMask;

  logic [LINES-1:0][ADDR_W-1:0] carAll;
  logic [LINES-1:0][EXT_W-1:0]  extAll;
  logic [LINES-1:0][ADDR_W-1:0] cntAll;
  logic [LINES-1:0]             lastAll;

  assign csrWr     = cfgWe && (cfgAddr == REG_CSR);
  assign carWr     = cfgWe && (cfgAddr == REG_CAR);
  assign cntWr     = cfgWe && (cfgAddr == REG_CNT);
  assign actWr     = cfgWe && (cfgAddr == REG_ACT);
  assign brkWr     = cfgWe && (cfgAddr == REG_BRK);
  assign mclrPulse = csrWr && cfgWdata[CSR_MCLR];

  generate
    for (genvar g = 0; g < LINES; g++) begin : gLine
      txdma_linereg #(.ADDR_W(ADDR_W), .EXT_W(EXT_W)) u_line (
        .clk      (clk),
        .rstN     (rstN),
        .clr      (mclrPulse),
        .carWe    (carWr && (selLine == SEL_W'(g))),
        .cntWe    (cntWr && (selLine == SEL_W'(g))),
        .bump     (step.advance && (svcLine == SEL_W'(g))),
        .wdata    (cfgWdata),
        .extIn    (extStage),
        .carOut   (carAll[g]),
        .extOut   (extAll[g]),
        .cntOut   (cntAll[g]),
        .lastByte (lastAll[g])
      );
    end
  endgenerate

  assign lineAddr = {extAll[svcLine], carAll[svcLine]};
  assign lineDone = step.advance && lastAll[svcLine];
  assign clrMask  = (lineDone || step.abort) ? (LINES'(1) << svcLine) : '0;

  // control/status fields
  always_ff @(posedge clk) begin
    if (!rstN) begin
      selLine  <= '0;
      extStage <= '0;
      doneEn   <= 1'b0;
      doneFlag <= 1'b0;
      nxmFlag  <= 1'b0;
    end else begin
      if (csrWr) begin
        selLine  <= cfgWdata[SEL_W-1:0];
        extStage <= cfgWdata[CSR_EXTLSB +: EXT_W];
        doneEn   <= cfgWdata[CSR_DONEEN];
        if (!cfgWdata[CSR_DONE])  doneFlag <= 1'b0;
        if (cfgWdata[CSR_NXMCLR]) nxmFlag  <= 1'b0;
      end
      if (lineDone || step.abort) doneFlag <= 1'b1;
      if (step.abort)             nxmFlag  <= 1'b1;
    end
  end

  // active and break bitmaps
  always_ff @(posedge clk) begin
    if (!rstN || mclrPulse) begin
      activeBits <= '0;
      breakBits  <= '0;
    end else begin
      activeBits <= (activeBits & ~clrMask) | (actWr ? cfgWdata[LINES-1:0] : '0);
      if (brkWr) breakBits <= cfgWdata[LINES-1:0];
    end
  end

  always_comb begin
    cfgRdata = '0;
    unique case (cfgAddr)
      REG_CSR: begin
        cfgRdata[CSR_DONE]               = doneFlag;
        cfgRdata[CSR_DONEEN]             = doneEn;
        cfgRdata[CSR_NXM]                = nxmFlag;
        cfgRdata[CSR_EXTLSB +: EXT_W]    = extAll[selLine];
        cfgRdata[SEL_W-1:0]              = selLine;
      end
      REG_CAR: cfgRdata = carAll[selLine];
      REG_CNT: cfgRdata = cntAll[selLine];
      REG_ACT: cfgRdata[LINES-1:0] = activeBits;
      REG_BRK: cfgRdata[LINES-1:0] = breakBits;
      default: cfgRdata = '0;
    endcase
  end

endmodule

// File: rtl/txdma_ctrl.sv
module txdma_ctrl
  import txdma_pkg::*;
#(
  parameter int LINES     = 16,
  parameter int MEM_AW    = 18,
  parameter int DATA_W    = 8,
  parameter int NXM_LIMIT = 32
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     mclr,
  input  logic [LINES-1:0]         activeBits,
  input  logic [LINES-1:0]         txReady,
  input  logic [MEM_AW-1:0]        lineAddr,
  output logic [$clog2(LINES)-1:0] svcLine,
  output logic                     memReq,
  output logic [MEM_AW-1:0]        memAddr,
  input  logic                     memAck,
  input  logic [DATA_W-1:0]        memData,
  output logic [LINES-1:0]         txLoad,
  output logic [DATA_W-1:0]        txByte,
  output stepStrobe_t              step
);

  localparam int SEL_W = $clog2(LINES);
  localparam int TMR_W = $clog2(NXM_LIMIT + 1);

  typedef enum logic {ST_IDLE, ST_FETCH} seqState_t;

  seqState_t        state;
  logic [SEL_W-1:0] lastLine, curLine, pick;
  logic [TMR_W-1:0] waitCnt;
  logic [LINES-1:0] eligible;
  logic             found, timedOut, gotByte;

  assign eligible = activeBits & txReady;

  // round-robin search starting one past the last served line
  always_comb begin
    found = 1'b0;
    pick  = lastLine;
    for (int k = 1; k <= LINES; k++) begin
      int idx;
      idx = (int'(lastLine) + k) % LINES;
      if (!found && eligible[idx]) begin
        found = 1'b1;
        pick  = SEL_W'(idx);
      end
    end
  end

  assign svcLine  = (state == ST_FETCH) ? curLine : pick;
  assign gotByte  = (state == ST_FETCH) && memAck && !mclr;
  assign timedOut = (state == ST_FETCH) && !memAck && !mclr &&
                    (waitCnt == TMR_W'(NXM_LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      lastLine <= SEL_W'(LINES - 1);
      curLine  <= '0;
      memAddr  <= '0;
      waitCnt  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          waitCnt <= '0;
          if (found && !mclr) begin
            state   <= ST_FETCH;
            curLine <= pick;
            memAddr <= lineAddr;
          end
        end
        ST_FETCH: begin
          waitCnt <= waitCnt + TMR_W'(1);
          if (mclr) begin
            state <= ST_IDLE;
          end else if (gotByte || timedOut) begin
            state    <= ST_IDLE;
            lastLine <= curLine;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign memReq       = (state == ST_FETCH);
  assign txLoad       = gotByte ? (LINES'(1) << curLine) : '0;
  assign txByte       = memData;
  assign step.advance = gotByte;
  assign step.abort   = timedOut;

endmodule

// File: rtl/txdma_mux.sv
module txdma_mux
  import txdma_pkg::*;
#(
  parameter int LINES     = 16,
  parameter int ADDR_W    = 16,
  parameter int EXT_W     = 2,
  parameter int DATA_W    = 8,
  parameter int NXM_LIMIT = 32
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    cfgWe,
  input  logic [2:0]              cfgAddr,
  input  logic [ADDR_W-1:0]       cfgWdata,
  output logic [ADDR_W-1:0]       cfgRdata,
  output logic                    memReq,
  output logic [EXT_W+ADDR_W-1:0] memAddr,
  input  logic                    memAck,
  input  logic [DATA_W-1:0]       memData,
  input  logic [LINES-1:0]        txReady,
  output logic [LINES-1:0]        txLoad,
  output logic [DATA_W-1:0]       txByte,
  output logic [LINES-1:0]        txSpace,
  output logic                    txIrq
);

  localparam int SEL_W  = $clog2(LINES);
  localparam int MEM_AW = EXT_W + ADDR_W;

  stepStrobe_t       stepBus;
  logic [SEL_W-1:0]  svcLine;
  logic [MEM_AW-1:0] lineAddr;
  logic [LINES-1:0]  activeBits;
  logic              lineDone, doneFlag, doneEn, nxmFlag, mclrPulse;

  txdma_dpath #(.LINES(LINES), .ADDR_W(ADDR_W), .EXT_W(EXT_W)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .cfgWe      (cfgWe),
    .cfgAddr    (cfgAddr),
    .cfgWdata   (cfgWdata),
    .cfgRdata   (cfgRdata),
    .svcLine    (svcLine),
    .step       (stepBus),
    .lineAddr   (lineAddr),
    .activeBits (activeBits),
    .breakBits  (txSpace),
    .lineDone   (lineDone),
    .doneFlag   (doneFlag),
    .doneEn     (doneEn),
    .nxmFlag    (nxmFlag),
    .mclrPulse  (mclrPulse)
  );

  txdma_ctrl #(.LINES(LINES), .MEM_AW(MEM_AW), .DATA_W(DATA_W), .NXM_LIMIT(NXM_LIMIT)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .mclr       (mclrPulse),
    .activeBits (activeBits),
    .txReady    (txReady),
    .lineAddr   (lineAddr),
    .svcLine    (svcLine),
    .memReq     (memReq),
    .memAddr    (memAddr),
    .memAck     (memAck),
    .memData    (memData),
    .txLoad     (txLoad),
    .txByte     (txByte),
    .step       (stepBus)
  );

  assign txIrq = doneFlag & doneEn;

endmodule

// File: rtl/txdma_chk.sv
module txdma_chk #(
  parameter int LINES  = 16,
  parameter int MEM_AW = 18
) (
  input logic              clk,
  input logic              rstN,
  input logic              memReq,
  input logic              memAck,
  input logic [MEM_AW-1:0] memAddr,
  input logic [LINES-1:0]  txLoad,
  input logic              stepAbort,
  input logic              mclrPulse,
  input logic              lineDone,
  input logic              doneFlag,
  input logic              nxmFlag,
  input logic [LINES-1:0]  activeBits
);

  // R2: a pending read holds request and address
  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck && !stepAbort && !mclrPulse) |=> (memReq && $stable(memAddr)));

  // R2: a load strobe only accompanies an acknowledged read
  p_load_ack_r2: assert property (@(posedge clk) disable iff (!rstN)
    (|txLoad) |-> (memReq && memAck));

  // R2: at most one line loaded per cycle
  p_load_onehot_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(txLoad));

  // R5: a finished line raises the done flag
  p_done_flag_r5: assert property (@(posedge clk) disable iff (!rstN)
    lineDone |=> doneFlag);

  // R9: a timed-out read raises both flags
  p_abort_nxm_r9: assert property (@(posedge clk) disable iff (!rstN)
    stepAbort |=> (nxmFlag && doneFlag));

  // R11: master clear empties the active bitmap
  p_mclr_r11: assert property (@(posedge clk) disable iff (!rstN)
    mclrPulse |=> (activeBits == '0));

endmodule

bind txdma_mux txdma_chk #(.LINES(LINES), .MEM_AW(EXT_W + ADDR_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .memReq     (memReq),
  .memAck     (memAck),
  .memAddr    (memAddr),
  .txLoad     (txLoad),
  .stepAbort  (stepBus.abort),
  .mclrPulse  (mclrPulse),
  .lineDone   (lineDone),
  .doneFlag   (doneFlag),
  .nxmFlag    (nxmFlag),
  .activeBits (activeBits)
);

// File: tb/txdma_mux_tb.sv
module txdma_mux_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NXM_LIM    = 32;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [2:0]  cfgAddr = '0;
  logic [15:0] cfgWdata = '0;
  logic [15:0] cfgRdata;
  logic        memReq;
  logic [17:0] memAddr;
  logic        memAck;
  logic [7:0]  memData;
  logic [15:0] txReady = '0;
  logic [15:0] txLoad;
  logic [7:0]  txByte;
  logic [15:0] txSpace;
  logic        txIrq;

  int checks = 0;
  int errors = 0;
  bit memOn = 1'b1;
  int latCnt = 0;

  int       logCnt = 0;
  int       logLine [0:63];
  logic [7:0] logByte [0:63];

  always #(CLK_PERIOD/2) clk = ~clk;

  txdma_mux #(.NXM_LIMIT(NXM_LIM)) u_dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .cfgRdata(cfgRdata), .memReq(memReq), .memAddr(memAddr), .memAck(memAck),
    .memData(memData), .txReady(txReady), .txLoad(txLoad), .txByte(txByte),
    .txSpace(txSpace), .txIrq(txIrq)
  );

  function automatic logic [7:0] memByte(input logic [17:0] a);
    return a[7:0] ^ {6'b0, a[17:16]} ^ 8'h5A;
  endfunction

  // memory model: acknowledge on the second cycle of a request
  initial begin
    memAck = 1'b0;
    memData = '0;
    forever begin
      @(posedge clk);
      #1;
      if (memAck) begin
        memAck = 1'b0;
        latCnt = 0;
      end else if (memReq && memOn) begin
        if (latCnt == 1) begin
          memAck  = 1'b1;
          memData = memByte(memAddr);
          latCnt  = 0;
        end else latCnt++;
      end else latCnt = 0;
    end
  end

  // load monitor, sampled mid-cycle
  always @(negedge clk) begin
    for (int i = 0; i < 16; i++) begin
      if (txLoad[i] && logCnt < 64) begin
        logLine[logCnt] = i;
        logByte[logCnt] = txByte;
        logCnt++;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = a; cfgWdata = d;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    cfgAddr = a;
    #1 d = cfgRdata;
  endtask

  // select line with done-enable set and done flag kept
  task automatic sel(input int line, input int ext);
    wr(3'd0, 16'hA000 | 16'(ext << 4) | 16'(line));
  endtask

  task automatic setLine(input int line, input int ext, input logic [15:0] a, input logic [15:0] c);
    sel(line, ext);
    wr(3'd1, a);
    wr(3'd2, c);
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rd(3'd0, v); chk("R1 reset csr", v, 16'h0000);
    rd(3'd3, v); chk("R4 reset active", v, 16'h0000);
    chk("R5 reset irq", txIrq, 0);
    chk("R2 reset memReq", memReq, 0);
    chk("R10 reset space", txSpace, 16'h0000);
  endtask

  task automatic t_window();
    logic [15:0] v;
    setLine(3, 0, 16'h1234, 16'hFFF0);
    setLine(4, 0, 16'h4321, 16'hFF00);
    sel(3, 0);
    rd(3'd1, v); chk("R1 line3 addr", v, 16'h1234);
    rd(3'd2, v); chk("R1 line3 count", v, 16'hFFF0);
    sel(4, 0);
    rd(3'd1, v); chk("R1 line4 addr", v, 16'h4321);
    rd(3'd0, v); chk("R1 csr select", v[3:0], 4);
  endtask

  task automatic t_roundrobin();
    logic [15:0] v;
    int expLine [0:5] = '{2, 5, 9, 2, 9, 9};
    logic [17:0] expA [0:5] = '{18'h00100, 18'h10200, 18'h30300, 18'h00101, 18'h30301, 18'h30302};
    int base;
    setLine(2, 0, 16'h0100, 16'hFFFE);
    setLine(5, 1, 16'h0200, 16'hFFFF);
    setLine(9, 3, 16'h0300, 16'hFFFD);
    txReady = 16'hFFFF;
    chk("R5 irq idle", txIrq, 0);
    base = logCnt;
    wr(3'd3, 16'h0224);
    waitCyc(40);
    chk("R2 load count", logCnt - base, 6);
    for (int i = 0; i < 6; i++) begin
      chk("R8 service order", logLine[base+i], expLine[i]);
      chk("R3 byte value", logByte[base+i], memByte(expA[i]));
    end
    rd(3'd3, v); chk("R4 active cleared", v, 16'h0000);
    sel(9, 0);
    rd(3'd1, v); chk("R3 final addr", v, 16'h0303);
    rd(3'd2, v); chk("R3 final count", v, 16'h0000);
    rd(3'd0, v); chk("R5 done flag", v[15], 1);
    chk("R5 irq raised", txIrq, 1);
    wr(3'd0, 16'h2009);
    rd(3'd0, v); chk("R5 done cleared", v[15], 0);
    chk("R5 irq dropped", txIrq, 0);
  endtask

  task automatic t_carry();
    logic [15:0] v;
    int base;
    setLine(7, 1, 16'hFFFF, 16'hFFFE);
    base = logCnt;
    wr(3'd3, 16'h0080);
    waitCyc(20);
    chk("R6 loads", logCnt - base, 2);
    chk("R6 byte before carry", logByte[base], memByte(18'h1FFFF));
    chk("R6 byte after carry", logByte[base+1], memByte(18'h20000));
    sel(7, 0);
    rd(3'd0, v); chk("R6 ext readback", v[5:4], 2);
    rd(3'd1, v); chk("R6 addr readback", v, 16'h0001);
  endtask

  task automatic t_stop();
    logic [15:0] v;
    int base;
    txReady = 16'hFFEF;
    setLine(4, 0, 16'h0400, 16'hFFF6);
    base = logCnt;
    wr(3'd3, 16'h0010);
    waitCyc(20);
    chk("R8 not ready no load", logCnt - base, 0);
    chk("R8 not ready no req", memReq, 0);
    rd(3'd3, v); chk("R8 still active", v[4], 1);
    wr(3'd2, 16'hFFFF);
    txReady = 16'hFFFF;
    waitCyc(20);
    chk("R7 one byte", logCnt - base, 1);
    chk("R7 byte value", logByte[base], memByte(18'h00400));
    rd(3'd3, v); chk("R7 active cleared", v[4], 0);
    rd(3'd1, v); chk("R7 stop addr", v, 16'h0401);
  endtask

  task automatic t_nxm();
    logic [15:0] v;
    int base;
    memOn = 1'b0;
    setLine(1, 0, 16'h0010, 16'hFFFD);
    base = logCnt;
    wr(3'd3, 16'h0002);
    waitCyc(NXM_LIM + 20);
    rd(3'd0, v); chk("R9 nxm flag", v[10], 1);
    chk("R9 done flag", v[15], 1);
    rd(3'd3, v); chk("R9 line dropped", v[1], 0);
    rd(3'd1, v); chk("R9 addr unchanged", v, 16'h0010);
    rd(3'd2, v); chk("R9 count unchanged", v, 16'hFFFD);
    chk("R9 no load", logCnt - base, 0);
    wr(3'd0, 16'hA101);
    rd(3'd0, v); chk("R9 nxm cleared", v[10], 0);
    memOn = 1'b1;
  endtask

  task automatic t_break();
    wr(3'd4, 16'h8001);
    @(negedge clk); chk("R10 space set", txSpace, 16'h8001);
    wr(3'd4, 16'h0000);
    @(negedge clk); chk("R10 space clear", txSpace, 16'h0000);
  endtask

  task automatic t_mclr();
    logic [15:0] v;
    txReady = 16'h0000;
    setLine(3, 2, 16'h0333, 16'hFFF0);
    wr(3'd3, 16'h0008);
    wr(3'd4, 16'h00F0);
    wr(3'd0, 16'hA803);
    rd(3'd3, v); chk("R11 active zero", v, 16'h0000);
    rd(3'd4, v); chk("R11 break zero", v, 16'h0000);
    chk("R11 space zero", txSpace, 16'h0000);
    rd(3'd1, v); chk("R11 addr zero", v, 16'h0000);
    rd(3'd2, v); chk("R11 count zero", v, 16'h0000);
    rd(3'd0, v); chk("R11 ext zero", v[5:4], 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_window();
    t_roundrobin();
    t_carry();
    t_stop();
    t_nxm();
    t_break();
    t_mclr();
    waitCyc(5);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule